// File: doc/BRIEF.md
# GPIO Port Controller with Per-Pin Interrupts

This block controls one port of general-purpose pins, up to eight of them, through a small memory-mapped register space. Each pin owns a 32-byte window of registers. In its window a pin can be switched on, turned into an output or left as an input, floated or driven, given an output level, and given an interrupt trigger. The trigger can be none, an active level, one edge chosen by a polarity bit, or both edges.

Pin inputs pass through a two-flop synchronizer. The synchronized level can be read back, and trigger detection works on it. Each pin keeps a pending bit. An edge sets it and it stays set until software writes a one to the pin's acknowledge register. In level mode the pending bit tracks the input condition. A single status word gathers the pending bits of all pins. One interrupt line combines the pending bits of the pins whose pin enable and interrupt enable are both set.

The register bus is single-cycle. A write is taken at the clock edge while the write strobe is high. Read data is combinational from the address.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads zero, every pin output enable is low (all pins floated) and the interrupt line is low.
- R2: The pin control word sits at byte offset 0x00 of window n, which starts at byte address n*0x20. Its bit fields are:
  - bit 0: pin enable
  - bit 1: output direction
  - bits 3:2: trigger type (0 none, 1 level, 2 single edge, 3 both edges)
  - bit 4: polarity
  - bit 6: interrupt enable

  These bits read back as written and all other bits read zero. Offset 0x04 holds an 8-bit threshold in bits 7:0 that reads back as written.
- R3: The output enable of pin n is high exactly when its pin enable and output direction bits are set and the float bit (bit 0 at offset 0x0C) is clear. The pin output follows bit 0 at offset 0x10.
- R4: Bit 0 at offset 0x08 reads the synchronized input level. It shows a change of the input two clock edges after the change, and writes to it are ignored.
- R5: In single-edge mode a rising edge sets pending when polarity is 1, and a falling edge sets it when polarity is 0. The edge of the other direction does not. Pending becomes visible on the third clock edge after the input change.
- R6: In both-edge mode either edge sets pending, whatever the polarity bit holds.
- R7: In level mode pending is high while the input is high (polarity 1) or low (polarity 0). An acknowledge does not remove it while the condition holds, and it drops once the condition ends.
- R8: An edge-mode pending bit stays set until a write with bit 0 set reaches offset 0x14 of its window. Writing 0 there has no effect. An edge detected in the same cycle as the acknowledge leaves pending set.
- R9: The status word at byte address 0x104 has pending of pin n in bit n. Bits at and above the pin count read zero, and writes to this address have no effect.
- R10: The interrupt line is the OR over pins of pending AND pin enable AND interrupt enable. A masked pending bit is still shown in the status word.
- R11: With trigger type none a pin never becomes pending.
- R12: Unused offsets inside a window, windows beyond the pin count and any other address read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_we_i | input | 1 | Write strobe, taken at the clock edge |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, combinational |
| pin_i | input | NUM_PINS | Pin input levels, asynchronous |
| pin_o | output | NUM_PINS | Pin output values |
| pin_oe_o | output | NUM_PINS | Pin output enables |
| irq_o | output | 1 | Combined port interrupt |

## Verification
The bench builds the block with NUM_PINS set to 6, against a default of 8. Windows 6 and 7 therefore exist in the address map but have no pin behind them, and status bits 6 and 7 must read zero. This brings the R9 and R12 cases for missing pins within reach. The address width and the two-stage synchronizer stay at their defaults, so the three-edge pending latency can be checked cycle by cycle. The single-edge, both-edge, level and none modes are each exercised on their own pin, along with the acknowledge that coincides with a new edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Register window geometry: each pin window spans 2**WIN_BITS bytes.
    localparam int WIN_BITS = 5;

    localparam logic [WIN_BITS-1:0] OFS_CTRL  = 5'h00;
    localparam logic [WIN_BITS-1:0] OFS_THRSH = 5'h04;
    localparam logic [WIN_BITS-1:0] OFS_LEVEL = 5'h08;
    localparam logic [WIN_BITS-1:0] OFS_FLOAT = 5'h0C;
    localparam logic [WIN_BITS-1:0] OFS_DRIVE = 5'h10;
    localparam logic [WIN_BITS-1:0] OFS_ACK   = 5'h14;

    typedef enum logic [1:0] {
        TRIG_OFF   = 2'd0,
        TRIG_LEVEL = 2'd1,
        TRIG_EDGE  = 2'd2,
        TRIG_BOTH  = 2'd3
    } trig_e;

    typedef struct packed {
        logic  irq_en;
        logic  pol_hi;
        trig_e trig;
        logic  out_dir;
        logic  pin_en;
    } pin_ctrl_t;

    typedef struct packed {
        pin_ctrl_t  ctrl;
        logic [7:0] thrsh;
        logic       floated;
        logic       drive;
        logic       pending;
    } slice_state_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] prev_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.chain[STAGES-1];
    assign prev_o  = st_q.prev;

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_port_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sel_i,
    input  logic                we_i,
    input  logic [WIN_BITS-1:0] ofs_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                level_i,
    input  logic                prev_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                pending_o,
    output logic                irq_req_o,
    output logic                pad_out_o,
    output logic                pad_oe_o
);

    slice_state_t st_d, st_q;

    logic wr_hit;
    logic ack_hit;
    logic rise;
    logic fall;
    logic trig_hit;

    always_comb begin
        st_d    = st_q;
        wr_hit  = sel_i && we_i;
        ack_hit = wr_hit && (ofs_i == OFS_ACK) && wdata_i[0];
        rise    = level_i && !prev_i;
        fall    = !level_i && prev_i;

        // Trigger condition under the current mode
        unique case (st_q.ctrl.trig)
            TRIG_OFF:   trig_hit = 1'b0;
            TRIG_LEVEL: trig_hit = (level_i == st_q.ctrl.pol_hi);
            TRIG_EDGE:  trig_hit = st_q.ctrl.pol_hi ? rise : fall;
            TRIG_BOTH:  trig_hit = rise || fall;
            default:    trig_hit = 1'b0;
        endcase

        // Level mode tracks the condition; edge modes are sticky with set priority
        unique case (st_q.ctrl.trig)
            TRIG_OFF:   st_d.pending = 1'b0;
            TRIG_LEVEL: st_d.pending = trig_hit;
            default:    st_d.pending = trig_hit || (st_q.pending && !ack_hit);
        endcase

        if (wr_hit) begin
            unique case (ofs_i)
                OFS_CTRL: begin
                    st_d.ctrl.pin_en  = wdata_i[0];
                    st_d.ctrl.out_dir = wdata_i[1];
                    st_d.ctrl.trig    = trig_e'(wdata_i[3:2]);
                    st_d.ctrl.pol_hi  = wdata_i[4];
                    st_d.ctrl.irq_en  = wdata_i[6];
                end
                OFS_THRSH: st_d.thrsh   = wdata_i[7:0];
                OFS_FLOAT: st_d.floated = wdata_i[0];
                OFS_DRIVE: st_d.drive   = wdata_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i) begin
            unique case (ofs_i)
                OFS_CTRL:  rdata_o = DATA_W'({1'b0, st_q.ctrl.irq_en, 1'b0, st_q.ctrl.pol_hi,
                                              st_q.ctrl.trig, st_q.ctrl.out_dir,
                                              st_q.ctrl.pin_en});
                OFS_THRSH: rdata_o = DATA_W'(st_q.thrsh);
                OFS_LEVEL: rdata_o = DATA_W'(level_i);
                OFS_FLOAT: rdata_o = DATA_W'(st_q.floated);
                OFS_DRIVE: rdata_o = DATA_W'(st_q.drive);
                default:   rdata_o = '0;
            endcase
        end
    end

    assign pending_o = st_q.pending;
    assign irq_req_o = st_q.pending && st_q.ctrl.pin_en && st_q.ctrl.irq_en;
    assign pad_out_o = st_q.drive;
    assign pad_oe_o  = st_q.ctrl.pin_en && st_q.ctrl.out_dir && !st_q.floated;

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter int STATUS_ADDR = 'h104
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic                reg_we_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] pin_o,
    output logic [NUM_PINS-1:0] pin_oe_o,
    output logic                irq_o
);

    localparam int SPAN = NUM_PINS << WIN_BITS;

    logic [NUM_PINS-1:0]             sync_lvl;
    logic [NUM_PINS-1:0]             sync_prv;
    logic [NUM_PINS-1:0]             pend_vec;
    logic [NUM_PINS-1:0]             req_vec;
    logic [NUM_PINS-1:0][DATA_W-1:0] slice_rd;
    logic [ADDR_W-1:0]               win_num;
    logic                            in_span;
    logic [WIN_BITS-1:0]             win_ofs;
    logic [DATA_W-1:0]               stat_word;

    assign win_num = reg_addr_i >> WIN_BITS;
    assign in_span = (reg_addr_i < ADDR_W'(SPAN));
    assign win_ofs = reg_addr_i[WIN_BITS-1:0];

    gpio_in_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .raw_i   (pin_i),
        .level_o (sync_lvl),
        .prev_o  (sync_prv)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        logic sel;
        assign sel = in_span && (win_num == ADDR_W'(n));

        gpio_pin_slice #(
            .DATA_W (DATA_W)
        ) i_slice (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .sel_i     (sel),
            .we_i      (reg_we_i),
            .ofs_i     (win_ofs),
            .wdata_i   (reg_wdata_i),
            .level_i   (sync_lvl[n]),
            .prev_i    (sync_prv[n]),
            .rdata_o   (slice_rd[n]),
            .pending_o (pend_vec[n]),
            .irq_req_o (req_vec[n]),
            .pad_out_o (pin_o[n]),
            .pad_oe_o  (pin_oe_o[n])
        );
    end

    always_comb begin
        stat_word                = '0;
        stat_word[NUM_PINS-1:0]  = pend_vec;
    end

    always_comb begin
        reg_rdata_o = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            reg_rdata_o = reg_rdata_o | slice_rd[n];
        end
        if (reg_addr_i == ADDR_W'(STATUS_ADDR)) begin
            reg_rdata_o = stat_word;
        end
    end

    assign irq_o = |req_vec;

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int NUM_PINS    = 8,
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int STATUS_ADDR = 'h104
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [ADDR_W-1:0]   addr_i,
    input logic                we_i,
    input logic [DATA_W-1:0]   rdata_i,
    input logic [NUM_PINS-1:0] oe_i,
    input logic [NUM_PINS-1:0] out_i,
    input logic                irq_i,
    input logic [NUM_PINS-1:0] pend_i
);

    localparam int SPAN = NUM_PINS << 5;

    // R1: right after reset release all pins are floated and no interrupt is raised
    p_reset_floated_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (oe_i == '0 && irq_i == 1'b0));

    // R3: an output enable can only turn on after a register write
    p_oe_after_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((oe_i & ~$past(oe_i)) != '0) |-> $past(we_i));

    // R9: status bits above the pin count read zero
    p_status_upper_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == ADDR_W'(STATUS_ADDR)) |-> ((rdata_i >> NUM_PINS) == '0));

    // R10: the interrupt line needs at least one pending pin
    p_irq_has_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> (pend_i != '0));

    // R12: writes outside the pin windows leave the pin outputs untouched
    p_outside_no_effect_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i >= ADDR_W'(SPAN)) |=> ($stable(oe_i) && $stable(out_i)));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
    .NUM_PINS    (NUM_PINS),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STATUS_ADDR (STATUS_ADDR)
) i_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .we_i    (reg_we_i),
    .rdata_i (reg_rdata_o),
    .oe_i    (pin_oe_o),
    .out_i   (pin_o),
    .irq_i   (irq_o),
    .pend_i  (pend_vec)
);

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;

    localparam int NP     = 6;
    localparam int AW     = 12;
    localparam int DW     = 32;
    localparam int STATUS = 'h104;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NP-1:0] pins = '0;
    logic [NP-1:0] pout;
    logic [NP-1:0] poe;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpio_port_ctrl #(
        .NUM_PINS (NP),
        .ADDR_W   (AW),
        .DATA_W   (DW)
    ) i_gpio_port_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_addr_i  (addr),
        .reg_we_i    (we),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pin_i       (pins),
        .pin_o       (pout),
        .pin_oe_o    (poe),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr  = AW'(a);
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
    endtask

    function automatic logic [31:0] peek(input int a);
        return 32'(rdata);
    endfunction

    task automatic rd(input int a, output logic [31:0] d);
        addr = AW'(a);
        #1;
        d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 oe", 32'(poe), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        rd('h00, v); check("R1 ctrl pin0", v, 0);
        rd('h44, v); check("R1 thrsh pin2", v, 0);
        rd(STATUS, v); check("R1 status", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr('h40, 32'hFFFF_FFFF);
        rd('h40, v); check("R2 ctrl readback", v, 32'h5F);
        wr('h64, 32'h1A5);
        rd('h64, v); check("R2 threshold", v, 32'hA5);
        wr('h40, 0);
        rd('h40, v); check("R2 ctrl cleared", v, 0);
    endtask

    task automatic t_drive();
        wr('h30, 1);
        wr('h20, 3);
        #1; check("R3 oe on", 32'(poe[1]), 1); check("R3 out", 32'(pout[1]), 1);
        wr('h2C, 1);
        #1; check("R3 floated", 32'(poe[1]), 0);
        wr('h2C, 0);
        #1; check("R3 unfloated", 32'(poe[1]), 1);
        wr('h30, 0);
        #1; check("R3 out low", 32'(pout[1]), 0);
        wr('h20, 1);
        #1; check("R3 input dir", 32'(poe[1]), 0);
        wr('h20, 0);
    endtask

    task automatic t_level_reg();
        logic [31:0] v;
        @(negedge clk);
        addr = 'h48;
        pins[2] = 1'b1;
        @(negedge clk); #1; v = rdata; check("R4 one edge", v, 0);
        @(negedge clk); #1; v = rdata; check("R4 two edges", v, 1);
        wr('h48, 0);
        rd('h48, v); check("R4 write ignored", v, 1);
        pins[2] = 1'b0;
        settle(3);
    endtask

    task automatic t_single_edge();
        logic [31:0] v;
        wr('h60, 32'h59);
        @(negedge clk); addr = STATUS; pins[3] = 1'b1;
        @(negedge clk); @(negedge clk); #1; v = rdata;
        check("R5 not yet", v, 0);
        @(negedge clk); #1; v = rdata;
        check("R5 rise third edge", v, 32'h08);
        check("R5 irq", 32'(irq), 1);
        wr('h74, 1);
        rd(STATUS, v); check("R8 ack clears", v, 0);
        pins[3] = 1'b0; settle(4);
        rd(STATUS, v); check("R5 fall ignored", v, 0);
        wr('h60, 32'h49);
        pins[3] = 1'b1; settle(4);
        rd(STATUS, v); check("R5 rise ignored pol0", v, 0);
        pins[3] = 1'b0; settle(4);
        rd(STATUS, v); check("R5 fall pol0", v, 32'h08);
        wr('h74, 0);
        rd(STATUS, v); check("R8 zero write keeps", v, 32'h08);
        wr('h74, 1);
        rd(STATUS, v); check("R8 cleared", v, 0);
        // acknowledge coinciding with a new falling edge
        pins[3] = 1'b1; settle(4);
        @(negedge clk); pins[3] = 1'b0;
        @(negedge clk);
        @(negedge clk); addr = 'h74; wdata = 1; we = 1'b1;
        @(negedge clk); we = 1'b0;
        rd(STATUS, v); check("R8 set beats ack", v, 32'h08);
        wr('h74, 1);
        wr('h60, 0);
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr('h80, 32'h4D);
        pins[4] = 1'b1; settle(4);
        rd(STATUS, v); check("R6 rise", v, 32'h10);
        wr('h94, 1);
        pins[4] = 1'b0; settle(4);
        rd(STATUS, v); check("R6 fall", v, 32'h10);
        wr('h94, 1);
        wr('h80, 32'h5D);
        pins[4] = 1'b1; settle(4);
        rd(STATUS, v); check("R6 pol ignored", v, 32'h10);
        wr('h94, 1);
        pins[4] = 1'b0; settle(4);
        wr('h94, 1);
        wr('h80, 0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr('hA0, 32'h55);
        settle(2);
        rd(STATUS, v); check("R7 idle", v, 0);
        pins[5] = 1'b1; settle(4);
        rd(STATUS, v); check("R7 high level", v, 32'h20);
        check("R7 irq", 32'(irq), 1);
        wr('hB4, 1); settle(1);
        rd(STATUS, v); check("R7 ack while held", v, 32'h20);
        pins[5] = 1'b0; settle(4);
        rd(STATUS, v); check("R7 drops", v, 0);
        wr('hA0, 32'h45); settle(2);
        rd(STATUS, v); check("R7 low level", v, 32'h20);
        wr('hA0, 0); settle(1);
        rd(STATUS, v); check("R7 mode off", v, 0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr('h80, 32'h0D);
        pins[4] = 1'b1; settle(4);
        rd(STATUS, v); check("R10 masked visible", v, 32'h10);
        check("R10 masked irq", 32'(irq), 0);
        wr('h80, 32'h4D);
        #1; check("R10 unmasked irq", 32'(irq), 1);
        wr('h80, 32'h4C);
        #1; check("R10 pin off irq", 32'(irq), 0);
        rd(STATUS, v); check("R10 still pending", v, 32'h10);
        // two pins pending at once
        wr('h60, 32'h59);
        pins[3] = 1'b1; settle(4);
        rd(STATUS, v); check("R9 two pins", v, 32'h18);
        wr(STATUS, 32'hFFFF_FFFF);
        rd(STATUS, v); check("R9 write ignored", v, 32'h18);
        wr('h74, 1); wr('h94, 1);
        wr('h60, 0); wr('h80, 0);
        pins[3] = 1'b0; pins[4] = 1'b0; settle(3);
    endtask

    task automatic t_none();
        logic [31:0] v;
        wr('h00, 32'h41);
        pins[0] = 1'b1; settle(4);
        pins[0] = 1'b0; settle(4);
        rd(STATUS, v); check("R11 no pending", v, 0);
        check("R11 irq", 32'(irq), 0);
        wr('h00, 0);
    endtask

    task automatic t_outside();
        logic [31:0] v;
        wr('hC0, 3);
        rd('hC0, v); check("R12 missing window", v, 0);
        check("R12 oe", 32'(poe), 0);
        wr('h18, 32'hFF);
        rd('h18, v); check("R12 unused offset", v, 0);
        rd('h100, v); check("R12 gap", v, 0);
        rd(STATUS, v); check("R9 upper zero", v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_drive();
        t_level_reg();
        t_single_edge();
        t_both();
        t_level();
        t_mask();
        t_none();
        t_outside();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule